// File: doc/BRIEF.md
# Sequential Leading-Zero Normalizer

This block takes an unsigned 32-bit operand and removes its leading zeros. It moves the operand left by one bit on each clock and stops once the top bit is 1. It also counts the moves in a 5-bit counter, and that count can later serve as a floating-point exponent. The operand is written one byte at a time into four byte lanes. Lane 0 holds the least significant byte and lane 3 the most significant byte. The same register then holds the result, and it can be read on `data_out`.

A caller fills the four lanes and pulses `start`. While the operand shifts, `busy` is high. When the run ends, `done` goes high for one cycle, and `data_out` and `shift_cnt` then hold the normalized value and its shift count. An all-zero operand cannot reach a set top bit. It therefore stops after the largest possible count of 31 and raises `zero`.

Top module: `lz_normalizer`

## Requirements
- R1: After a synchronous reset, `data_out` is 0, `shift_cnt` is 0, and `busy`, `done` and `zero` are all 0.
- R2: While idle, a clock edge with `byte_we` high writes `byte_din` into lane `byte_idx`. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24. The written value shows on `data_out` after that edge.
- R3: A `start` sampled while idle makes `busy` 1 and `shift_cnt` 0 on the next edge.
- R4: On each later busy edge where bit 31 is 0 and the count is below 31, the operand moves left by one bit, a 0 enters bit 0, and `shift_cnt` goes up by 1.
- R5: A run ends on the first busy edge where bit 31 is 1 or the count is 31. At that edge `busy` falls and `done` is high for exactly one cycle. `shift_cnt` then equals the number of leading zeros of the operand, capped at 31. `done` arrives count+1 edges after the start edge.
- R6: An operand with bit 31 already set finishes with a count of 0, an unchanged value and `done` on the second edge after `start`.
- R7: An all-zero operand finishes after 31 shifts with `shift_cnt` = 31, `data_out` = 0 and `zero` = 1. For any non-zero operand, `zero` is 0. `zero` holds until the next accepted `start`.
- R8: While `busy` is high, `start` and `byte_we` have no effect: the run and its result are the same as without them.
- R9: After `done`, `data_out` and `shift_cnt` keep their values until the next byte write or accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_we | input | 1 | Write enable for one operand lane |
| byte_idx | input | 2 | Lane select, 0 = least significant byte |
| byte_din | input | 8 | Byte to write |
| start | input | 1 | Begin a normalize run |
| data_out | output | 32 | Operand / normalized result |
| shift_cnt | output | 5 | Number of left shifts performed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| zero | output | 1 | Last run saw an all-zero operand |

## Verification
The properties assume that `rst` is applied before the first run. They make no assumption about `start` or `byte_we` while busy, since the design must ignore both. The stimulus therefore writes lanes only while idle for the main runs, and it deliberately drives `start` and a lane write in the middle of one run to exercise R8. Random operands are drawn from a fixed seed and shifted right by a random amount, so that every leading-zero count from 0 to 31 is likely. The all-zero, all-ones, single-low-bit and top-bit-set operands are added as directed cases.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } nrm_state_t;
endpackage

// File: rtl/nrm_operand_reg.sv
module nrm_operand_reg #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [SEL_W-1:0]  load_sel,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift_en,
  output logic [DATA_W-1:0] value_q,
  output logic              msb,
  output logic              is_zero
);
  logic [DATA_W-1:0] value_d;
  logic [DATA_W-1:0] shifted;

  assign shifted = {value_q[DATA_W-2:0], 1'b0};

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic hit;
    assign hit = load_en && (load_sel == SEL_W'(g));
    always_comb begin
      if (hit)
        value_d[g*BYTE_W +: BYTE_W] = load_byte;
      else if (shift_en)
        value_d[g*BYTE_W +: BYTE_W] = shifted[g*BYTE_W +: BYTE_W];
      else
        value_d[g*BYTE_W +: BYTE_W] = value_q[g*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) value_q <= '0;
    else     value_q <= value_d;
  end

  assign msb     = value_q[DATA_W-1];
  assign is_zero = (value_q == '0);
endmodule

// File: rtl/nrm_shift_counter.sv
module nrm_shift_counter #(
  parameter int CNT_W = 5,
  parameter int MAX_CNT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_max
);
  always_ff @(posedge clk) begin
    if (rst || clear)               cnt_q <= '0;
    else if (inc && !at_max)        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_max = (cnt_q == CNT_W'(MAX_CNT));
endmodule

// File: rtl/nrm_ctrl.sv
module nrm_ctrl
  import nrm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic byte_we,
  input  logic msb,
  input  logic cnt_max,
  input  logic op_zero,
  output logic load_en,
  output logic shift_en,
  output logic cnt_clear,
  output logic busy,
  output logic done,
  output logic zero
);
  nrm_state_t state_q, state_d;
  logic accept, finish;

  assign busy     = (state_q == ST_RUN);
  assign accept   = start && !busy;
  assign finish   = busy && (msb || cnt_max);
  assign shift_en = busy && !finish;
  assign load_en  = byte_we && !busy;
  assign cnt_clear = accept;

  always_comb begin
    state_d = state_q;
    if (accept)      state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      zero    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= finish;
      if (accept)      zero <= 1'b0;
      else if (finish) zero <= op_zero;
    end
  end
endmodule

// File: rtl/lz_normalizer.sv
module lz_normalizer #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_we,
  input  logic [SEL_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_din,
  input  logic              start,
  output logic [DATA_W-1:0] data_out,
  output logic [CNT_W-1:0]  shift_cnt,
  output logic              busy,
  output logic              done,
  output logic              zero
);
  logic load_en, shift_en, cnt_clear, msb, op_zero, cnt_max;

  nrm_operand_reg #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_op (
    .clk(clk), .rst(rst), .load_en(load_en), .load_sel(byte_idx),
    .load_byte(byte_din), .shift_en(shift_en), .value_q(data_out),
    .msb(msb), .is_zero(op_zero)
  );

  nrm_shift_counter #(.CNT_W(CNT_W), .MAX_CNT(DATA_W-1)) u_cnt (
    .clk(clk), .rst(rst), .clear(cnt_clear), .inc(shift_en),
    .cnt_q(shift_cnt), .at_max(cnt_max)
  );

  nrm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .byte_we(byte_we), .msb(msb),
    .cnt_max(cnt_max), .op_zero(op_zero), .load_en(load_en),
    .shift_en(shift_en), .cnt_clear(cnt_clear), .busy(busy),
    .done(done), .zero(zero)
  );
endmodule

// File: rtl/nrm_checker.sv
module nrm_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [DATA_W-1:0] data_out,
  input logic [CNT_W-1:0]  shift_cnt,
  input logic              busy,
  input logic              done,
  input logic              zero
);
  // R3: accepted start opens a run with a cleared counter
  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && shift_cnt == '0));

  // R4: each continuing busy cycle shifts by exactly one with a zero fill
  a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (data_out == {$past(data_out[DATA_W-2:0]), 1'b0}
                               && shift_cnt == $past(shift_cnt) + CNT_W'(1)));

  // R5: completion only with top bit set or count at its cap
  a_r5_end_cond: assert property (@(posedge clk) disable iff (rst)
    done |-> (data_out[DATA_W-1] || shift_cnt == CNT_W'(DATA_W-1)));

  // R5: done is a single-cycle pulse that never overlaps busy
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $fell(busy)));

  // R7: zero flag agrees with the result at completion
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (zero == (data_out == '0)));

  // R9: result is stable between completion and a new start
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(done) && !$past(start) && !busy && !done) |-> $stable(shift_cnt));
endmodule

bind lz_normalizer nrm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .data_out(data_out),
  .shift_cnt(shift_cnt), .busy(busy), .done(done), .zero(zero)
);

// File: tb/lz_normalizer_test.sv
module lz_normalizer_test;
  logic clk = 1'b0;
  logic rst, byte_we, start;
  logic [1:0] byte_idx;
  logic [7:0] byte_din;
  logic [31:0] data_out;
  logic [4:0] shift_cnt;
  logic busy, done, zero;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lz_normalizer uut (
    .clk(clk), .rst(rst), .byte_we(byte_we), .byte_idx(byte_idx),
    .byte_din(byte_din), .start(start), .data_out(data_out),
    .shift_cnt(shift_cnt), .busy(busy), .done(done), .zero(zero)
  );

  function automatic int lz_of(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) if (w[i]) return 31 - i;
    return 31;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      byte_we = 1'b1; byte_idx = 2'(b); byte_din = w[b*8 +: 8];
    end
    @(negedge clk);
    byte_we = 1'b0;
    check("R2 load", data_out, w);
  endtask

  task automatic run(input logic [31:0] w, input bit disturb);
    int k, cycles;
    logic [31:0] exp_d;
    k = lz_of(w);
    exp_d = w << k;
    load_word(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 busy", {31'd0, busy}, 32'd1);
    check("R3 cnt clear", {27'd0, shift_cnt}, 32'd0);
    cycles = 0;
    while (!done && cycles < 40) begin
      if (disturb && cycles == 1) begin
        start = 1'b1; byte_we = 1'b1; byte_idx = 2'd3; byte_din = 8'hA5;
      end else begin
        start = 1'b0; byte_we = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    start = 1'b0; byte_we = 1'b0;
    check(disturb ? "R8 data" : "R5 data", data_out, exp_d);
    check(disturb ? "R8 cnt" : "R5 cnt", {27'd0, shift_cnt}, 32'(k));
    check("R5 latency", 32'(cycles), 32'(k + 1));
    check("R5 busy low", {31'd0, busy}, 32'd0);
    check("R7 zero flag", {31'd0, zero}, {31'd0, (w == 0)});
    if (w[31]) check("R6 msb set", {27'd0, shift_cnt}, 32'd0);
    @(negedge clk);
    check("R5 done pulse", {31'd0, done}, 32'd0);
    check("R9 hold data", data_out, exp_d);
    check("R9 hold cnt", {27'd0, shift_cnt}, 32'(k));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    logic [31:0] w;
    rst = 1'b1; byte_we = 1'b0; start = 1'b0; byte_idx = '0; byte_din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 data", data_out, 32'd0);
    check("R1 cnt", {27'd0, shift_cnt}, 32'd0);
    check("R1 flags", {29'd0, busy, done, zero}, 32'd0);
    run(32'h0000_0000, 1'b0);   // R7
    check("R7 zero held", {31'd0, zero}, 32'd1);
    run(32'h8000_0000, 1'b0);   // R6
    run(32'hFFFF_FFFF, 1'b0);   // R6
    run(32'h0000_0001, 1'b0);   // R5 full 31 shifts, nonzero
    run(32'h0001_0000, 1'b0);
    run(32'h0000_3C00, 1'b1);   // R8
    seed = 32'h1234;
    void'($urandom(seed));
    for (int i = 0; i < 40; i++) begin
      w = $urandom() >> ($urandom() % 32);
      run(w, (i % 7) == 3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule